// File: doc/BRIEF.md
# Pipelined Packed Signed Multiply and Pair-Sum Unit

This block takes two 64-bit operands and splits each into four signed 16-bit lanes. It multiplies lane by lane to form four 32-bit signed products. The 2-bit operation code then picks the result. The result can be the low half of each product or the high half of each product, packed into four 16-bit lanes. It can also be two 32-bit dot-product partial sums, each made from a pair of neighbouring products.

The unit is a three-stage pipeline with no stall path. It accepts one operation on every clock. The operation code and a valid flag travel through the stages with the data, so consecutive operations of different kinds each come out correctly. There is no accumulator or third operand inside the unit. A running total is built downstream by a separate packed 32-bit adder.

The pipeline has no control states beyond its per-stage valid flags. A stage is either idle (valid low) or occupied (valid high). The only transitions are "capture", when a stage takes a valid entry from the stage before it, and "drain", when it takes an idle entry. A synchronous reset forces every stage to idle.

Top module: `simd_mul_pipe`

## Requirements
- R1: Lane i of each operand is bits [16i+15:16i], read as two's complement. Lane i of `in_a` times lane i of `in_b` gives a 32-bit signed product p_i.
- R2: Operation code 0 (low halves) returns p_i[15:0] in result bits [16i+15:16i] for each of the four lanes.
- R3: Operation code 1 (high halves) returns p_i[31:16] in result bits [16i+15:16i] for each of the four lanes.
- R4: Operation code 2 (pair sum) returns p0+p1 in result bits [31:0] and p2+p3 in bits [63:32], wrapped modulo 2^32. When all four lane pairs are -32768 times -32768, each half is 0x80000000.
- R5: `out_valid` rises exactly three clock cycles after `in_valid` is sampled high. The matching result is on `out_result` in that same cycle.
- R6: One operation is accepted every clock. Back-to-back operations with differing operation codes each produce their own correct result, in issue order.
- R7: Operation code 3 is reserved. It produces an all-zero result, with `out_valid` still asserted after three cycles.
- R8: When `out_valid` is low, `out_result` is zero. Operands presented with `in_valid` low have no effect on the output.
- R9: A synchronous reset clears every stage valid flag and the output register. Operations in flight when reset is applied never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_op | input | 2 | Operation code: 0 low halves, 1 high halves, 2 pair sum, 3 reserved |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result present on `out_result` |
| out_result | output | 64 | Packed result |

## Verification
Every result is due on the third rising edge after the edge that samples its operation. The bench drives each operation just after a falling edge. It reads the outputs on the falling edge three cycles after issue, so the sample point falls half a period after the result register loads. The bench streams sequences through the pipeline with a fixed cycle index. At index t it compares the outputs against the entry issued at index t-3, or against the idle value (valid low, result zero) when no valid entry sits there. The reset test checks that entries caught mid-pipeline never appear in the following four cycles.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    typedef enum logic [1:0] {
        MUL_LO   = 2'd0,
        MUL_HI   = 2'd1,
        MUL_PAIR = 2'd2,
        MUL_RSV  = 2'd3
    } mul_op_e;

endpackage

// File: rtl/lane_mult.sv
module lane_mult #(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    output logic [2*W-1:0]     prod
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod_next;
    logic                 primed;

    always_comb begin
        prod_next = $signed(opa) * $signed(opb);
    end

    always_ff @(posedge clk) begin
        prod <= prod_next;
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R1: a nonzero product carries the xor of the operand signs
    a_r1_product_sign: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(opa) != '0 && $past(opb) != '0)
        |-> (prod[PW-1] == ($past(opa[W-1]) ^ $past(opb[W-1]))));

endmodule

// File: rtl/result_pack.sv
module result_pack
    import simd_mul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16
) (
    input  mul_op_e                        op,
    input  logic [LANES*2*LANE_W-1:0]      prods,
    output logic [LANES*LANE_W-1:0]        res
);
    localparam int PW    = 2 * LANE_W;
    localparam int PAIRS = LANES / 2;

    logic [LANES*LANE_W-1:0] lo_pack;
    logic [LANES*LANE_W-1:0] hi_pack;
    logic [PAIRS*PW-1:0]     sum_pack;

    for (genvar i = 0; i < LANES; i++) begin : g_half
        assign lo_pack[i*LANE_W +: LANE_W] = prods[i*PW +: LANE_W];
        assign hi_pack[i*LANE_W +: LANE_W] = prods[i*PW + LANE_W +: LANE_W];
    end

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign sum_pack[k*PW +: PW] = prods[(2*k)*PW +: PW] + prods[(2*k+1)*PW +: PW];
    end

    always_comb begin
        unique case (op)
            MUL_LO:   res = lo_pack;
            MUL_HI:   res = hi_pack;
            MUL_PAIR: res = sum_pack;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/simd_mul_pipe.sv
module simd_mul_pipe
    import simd_mul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              in_op,
    input  logic [LANES*LANE_W-1:0] in_a,
    input  logic [LANES*LANE_W-1:0] in_b,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_result
);
    localparam int DW = LANES * LANE_W;
    localparam int PW = 2 * LANE_W;

    // stage 1: operand capture
    logic          s1_v;
    mul_op_e       s1_op;
    logic [DW-1:0] s1_a, s1_b;

    // stage 2: products
    logic                s2_v;
    mul_op_e             s2_op;
    logic [LANES*PW-1:0] s2_prod;
    logic [DW-1:0]       s2_res;

    // cycles since reset, saturating, for assertion windows
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v  <= 1'b0;
            s1_op <= MUL_LO;
            s2_v  <= 1'b0;
            s2_op <= MUL_LO;
            age   <= 2'd0;
        end else begin
            s1_v  <= in_valid;
            s1_op <= mul_op_e'(in_op);
            s2_v  <= s1_v;
            s2_op <= s1_op;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        s1_a <= in_a;
        s1_b <= in_b;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_mult #(.W(LANE_W)) u_mult (
            .clk  (clk),
            .rst  (rst),
            .opa  (s1_a[i*LANE_W +: LANE_W]),
            .opb  (s1_b[i*LANE_W +: LANE_W]),
            .prod (s2_prod[i*PW +: PW])
        );
    end

    result_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
        .op    (s2_op),
        .prods (s2_prod),
        .res   (s2_res)
    );

    // stage 3: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s2_v;
            out_result <= s2_v ? s2_res : '0;
        end
    end

    // R5: output valid follows input valid by exactly three cycles
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R8: an idle output carries no data
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_result == '0));

    // R7: reserved code yields zero data
    a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && out_valid && $past(s2_op) == MUL_RSV) |-> (out_result == '0));

    // R9: first cycle after reset has an empty output
    a_r9_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/simd_mul_pipe_tb_top.sv
`timescale 1ns/1ps
module simd_mul_pipe_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    simd_mul_pipe dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // stream storage
    logic        st_v  [8];
    logic [1:0]  st_op [8];
    logic [63:0] st_a  [8];
    logic [63:0] st_b  [8];
    int          st_n;

    function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
        logic signed [31:0] p [4];
        logic [63:0] r;
        for (int i = 0; i < 4; i++) p[i] = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
        r = '0;
        case (op)
            2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
            2'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
            2'd2: begin
                r[31:0]  = p[0] + p[1];
                r[63:32] = p[2] + p[3];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [63:0] pk(int l3, int l2, int l1, int l0);
        return {l3[15:0], l2[15:0], l1[15:0], l0[15:0]};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ent(int i, logic v, logic [1:0] op, logic [63:0] a, logic [63:0] b);
        st_v[i] = v; st_op[i] = op; st_a[i] = a; st_b[i] = b;
    endtask

    // drive entries back to back; entry t is due at index t+3
    task automatic run_stream(string tag);
        for (int t = 0; t < st_n + 3; t++) begin
            @(negedge clk);
            if (t >= 3 && st_v[t-3]) begin
                chk({tag, " R5 valid"}, {63'd0, out_valid}, 64'd1);
                chk(tag, out_result, model(st_op[t-3], st_a[t-3], st_b[t-3]));
            end else begin
                chk({tag, " R8 idle valid"}, {63'd0, out_valid}, 64'd0);
                chk({tag, " R8 idle data"}, out_result, 64'd0);
            end
            if (t < st_n) begin
                in_valid = st_v[t]; in_op = st_op[t]; in_a = st_a[t]; in_b = st_b[t];
            end else begin
                in_valid = 1'b0; in_op = 2'd0; in_a = '0; in_b = '0;
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset data", out_result, 64'd0);
    endtask

    task automatic t_low;
        st_n = 2;
        set_ent(0, 1, 2'd0, pk(3, -2, 300, 7), pk(5, 9, 400, -1));
        set_ent(1, 1, 2'd0, pk(-32768, 32767, 1, 0), pk(-32768, 32767, -1, 1234));
        run_stream("R2 low");
    endtask

    task automatic t_high;
        st_n = 2;
        set_ent(0, 1, 2'd1, pk(1000, -1000, 32767, -32768), pk(1000, 1000, 32767, 32767));
        set_ent(1, 1, 2'd1, pk(-1, 2, -3, 4), pk(-1, -2, 3, 4));
        run_stream("R3 high");
    endtask

    task automatic t_pair;
        st_n = 3;
        set_ent(0, 1, 2'd2, pk(1, 2, 3, 4), pk(5, 6, 7, 8));
        set_ent(1, 1, 2'd2, pk(-32768, -32768, -32768, -32768), pk(-32768, -32768, -32768, -32768));
        set_ent(2, 1, 2'd2, pk(-200, 300, 12345, -4321), pk(77, -11, -9, 8));
        run_stream("R4 pair");
        // explicit value for the overflow corner: both halves 0x80000000
        chk("R4 overflow model", model(2'd2, {4{16'h8000}}, {4{16'h8000}}), 64'h80000000_80000000);
    endtask

    task automatic t_mixed;
        st_n = 6;
        set_ent(0, 1, 2'd0, pk(11, -12, 13, -14), pk(-15, 16, 17, 18));
        set_ent(1, 1, 2'd1, pk(20000, -20000, 123, 9), pk(3, 3, -456, 9));
        set_ent(2, 1, 2'd2, pk(100, 200, -300, 400), pk(5, -6, 7, 8));
        set_ent(3, 1, 2'd3, pk(999, 999, 999, 999), pk(999, 999, 999, 999));
        set_ent(4, 1, 2'd1, pk(-32768, 1, 2, 3), pk(2, 4, 6, 8));
        set_ent(5, 1, 2'd2, pk(32767, 32767, 1, 1), pk(32767, 32767, 1, 1));
        run_stream("R6 R7 mixed");
    endtask

    task automatic t_gaps;
        st_n = 5;
        set_ent(0, 1, 2'd2, pk(9, 8, 7, 6), pk(1, 2, 3, 4));
        set_ent(1, 0, 2'd1, pk(-1, -1, -1, -1), pk(5, 5, 5, 5));
        set_ent(2, 0, 2'd2, pk(4321, 8765, 1, 2), pk(3, 4, 5, 6));
        set_ent(3, 1, 2'd0, pk(-7, 7, -7, 7), pk(7, 7, -7, -7));
        set_ent(4, 0, 2'd3, pk(1, 1, 1, 1), pk(1, 1, 1, 1));
        run_stream("R8 gaps");
    endtask

    task automatic t_flush;
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd0; in_a = pk(1, 2, 3, 4); in_b = pk(1, 1, 1, 1);
        @(negedge clk);
        in_op = 2'd2; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R9 flush valid", {63'd0, out_valid}, 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_low();
        t_high();
        t_pair();
        t_mixed();
        t_gaps();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule